// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This block adjusts address bit 6 of byte addresses issued against tiled surfaces. With two interleaved memory channels, the channel select follows bit 6. The tiled-surface engine also folds higher address bits into that select. A CPU-side access must therefore apply the same XOR to land on the same bytes. The block keeps one swizzle mode for X-tiled surfaces and one for Y-tiled surfaces. Each mode is a set of higher address bits that are XORed into bit 6.

Both modes are decoded from a memory-configuration word and a flag that marks modified (L-shaped) addressing. The decoded modes are captured when a load strobe is pulsed. Some configurations cannot be trusted:

- a configuration word of all ones, which marks a failed read of the controller;
- an unassigned addressing code;
- modified addressing.

For any of these, the block reports no swizzling for both tiling types. It also raises a sticky flag that tells software to pin pages in place. The address path itself is combinational. An untiled access passes through unchanged.

Top module: `bit6_swizzle_unit`

## Requirements
- R1: After a synchronous active-low reset, `mode_x` and `mode_y` are 0 (none) and `pin_pages` is 0. Mode codes are: 0 none, 1 bit 9, 2 bits 9 and 10, 3 bits 9 and 11, 4 bits 9, 10 and 11, 5 bits 9 and 17, 6 bits 9, 10 and 17.
- R2: A load with addressing code `cfg_word[1:0]` equal to 00 (single channel) or 01 (asymmetric dual channel) sets both modes to 0.
- R3: A load with addressing code 10 (interleaved) and the XOR-disable bit `cfg_word[10]` set gives mode_x 2 and mode_y 1.
- R4: A load with code 10, `cfg_word[10]` clear and the bit-17 select `cfg_word[9]` clear gives mode_x 4 and mode_y 3.
- R5: A load with code 10, `cfg_word[10]` clear and `cfg_word[9]` set gives mode_x 6 and mode_y 5.
- R6: A load is unknown when any of these holds: `cfg_word` is all ones, `cfg_l_shaped` is 1, or the addressing code is 11. An unknown load sets both modes to 0 and sets `pin_pages`. Code 7 is never reported.
- R7: `pin_pages` stays at 1 through all later loads until reset.
- R8: Without `cfg_load`, `mode_x`, `mode_y` and `pin_pages` hold their values.
- R9: For `acc_tiling` 01 (X) the mode used is `mode_x`; for 10 (Y) it is `mode_y`. `out_addr[6]` equals `acc_addr[6]` XORed with every address bit of that mode, in the same cycle.
- R10: For `acc_tiling` 00 or 11 (untiled), `out_addr` equals `acc_addr`. In all cases, no bit other than bit 6 ever differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Capture modes decoded from the configuration inputs |
| cfg_word | input | CFG_W | Memory configuration word |
| cfg_l_shaped | input | 1 | Modified (L-shaped) addressing active |
| acc_tiling | input | 2 | Access tiling: 00 none, 01 X, 10 Y, 11 none |
| acc_addr | input | ADDR_W | Byte address of the access |
| out_addr | output | ADDR_W | Swizzled byte address |
| mode_x | output | 3 | Current X-tiled mode code |
| mode_y | output | 3 | Current Y-tiled mode code |
| pin_pages | output | 1 | Sticky flag: an unknown configuration was loaded |

## Verification
The unknown path is the hardest to reach from the ports. Random 32-bit words almost never read as all ones, and the L-shaped flag can hide behind an otherwise valid interleaved word. The stimulus therefore biases word choice toward the all-ones value, toward each addressing code, and toward an occasional set flag. It also loads valid configurations after an unknown one, which shows that the pin flag survives and that only a reset clears it.

// File: rtl/swz_pkg.sv
// Package: shared mode codes for the bit-6 swizzle unit.
// Assumes: codes 0..6 are the reportable modes; 7 marks an unknown decode only.
package swz_pkg;
    typedef enum logic [2:0] {
        SWZ_NONE      = 3'd0,
        SWZ_9         = 3'd1,
        SWZ_9_10      = 3'd2,
        SWZ_9_11      = 3'd3,
        SWZ_9_10_11   = 3'd4,
        SWZ_9_17      = 3'd5,
        SWZ_9_10_17   = 3'd6,
        SWZ_UNKNOWN   = 3'd7
    } swz_mode_t;

    typedef enum logic [1:0] {
        CH_SINGLE     = 2'b00,
        CH_ASYM       = 2'b01,
        CH_INTERLEAVE = 2'b10,
        CH_RESERVED   = 2'b11
    } chan_mode_t;
endpackage

// File: rtl/swz_mode_decode.sv
// Module: swz_mode_decode
// Maps the configuration word and the L-shaped flag to X and Y swizzle modes.
// Assumes: field positions are set by parameters; purely combinational.
module swz_mode_decode #(
    parameter int CFG_W      = 32,
    parameter int CHMODE_LSB = 0,
    parameter int SEL17_BIT  = 9,
    parameter int XORDIS_BIT = 10
) (
    input  logic [CFG_W-1:0]     cfg_word,
    input  logic                 cfg_l_shaped,
    output swz_pkg::swz_mode_t   dec_x,
    output swz_pkg::swz_mode_t   dec_y,
    output logic                 dec_unknown
);
    import swz_pkg::*;

    localparam logic [CFG_W-1:0] ALL_ONES = {CFG_W{1'b1}};

    chan_mode_t ch;
    logic       read_failed;

    // Extract the addressing code and detect a failed controller read.
    always_comb begin
        ch          = chan_mode_t'(cfg_word[CHMODE_LSB +: 2]);
        read_failed = (cfg_word == ALL_ONES);
    end

    // Select the raw mode pair; unknown cases yield the unknown code.
    always_comb begin
        swz_mode_t rx;
        swz_mode_t ry;
        case (ch)
            CH_SINGLE, CH_ASYM: begin
                rx = SWZ_NONE;
                ry = SWZ_NONE;
            end
            CH_INTERLEAVE: begin
                if (cfg_word[XORDIS_BIT]) begin
                    rx = SWZ_9_10;
                    ry = SWZ_9;
                end else if (!cfg_word[SEL17_BIT]) begin
                    rx = SWZ_9_10_11;
                    ry = SWZ_9_11;
                end else begin
                    rx = SWZ_9_10_17;
                    ry = SWZ_9_17;
                end
            end
            default: begin
                rx = SWZ_UNKNOWN;
                ry = SWZ_UNKNOWN;
            end
        endcase
        if (read_failed || cfg_l_shaped) begin
            rx = SWZ_UNKNOWN;
            ry = SWZ_UNKNOWN;
        end
        dec_unknown = (rx == SWZ_UNKNOWN) || (ry == SWZ_UNKNOWN);
        dec_x       = dec_unknown ? SWZ_NONE : rx;
        dec_y       = dec_unknown ? SWZ_NONE : ry;
    end
endmodule

// File: rtl/swz_mode_regs.sv
// Module: swz_mode_regs
// Holds the active X/Y modes and the sticky pin-pages flag.
// Assumes: decoded inputs are never the unknown code; synchronous active-low reset.
module swz_mode_regs (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  swz_pkg::swz_mode_t dec_x,
    input  swz_pkg::swz_mode_t dec_y,
    input  logic               dec_unknown,
    output swz_pkg::swz_mode_t mode_x,
    output swz_pkg::swz_mode_t mode_y,
    output logic               pin_pages
);
    import swz_pkg::*;

    // Capture modes on load; pin flag only ever sets until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_x    <= SWZ_NONE;
            mode_y    <= SWZ_NONE;
            pin_pages <= 1'b0;
        end else if (load) begin
            mode_x    <= dec_x;
            mode_y    <= dec_y;
            pin_pages <= pin_pages | dec_unknown;
        end
    end

    // R8: registers hold without a load strobe
    assert_hold_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> ($stable(mode_x) && $stable(mode_y) && $stable(pin_pages)));

    // R7: pin flag is sticky
    assert_pin_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pin_pages)) |-> pin_pages);

    // R6: an unknown load always leaves the pin flag set and both modes none
    assert_unknown_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dec_unknown) |=> (pin_pages && mode_x == SWZ_NONE && mode_y == SWZ_NONE));

    // R6: the unknown code is never held
    assert_no_unknown_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_x != SWZ_UNKNOWN) && (mode_y != SWZ_UNKNOWN));
endmodule

// File: rtl/swz_addr_xor.sv
// Module: swz_addr_xor
// Folds the address bits named by a mode into bit 6; all other bits pass.
// Assumes: ADDR_W >= 18 so bit 17 exists; combinational.
module swz_addr_xor #(
    parameter int ADDR_W = 32
) (
    input  swz_pkg::swz_mode_t  mode,
    input  logic [ADDR_W-1:0]   addr_in,
    output logic [ADDR_W-1:0]   addr_out
);
    import swz_pkg::*;

    localparam int SWZ_BIT = 6;

    logic flip;

    // Parity of the bits that the mode folds into bit 6.
    always_comb begin
        case (mode)
            SWZ_9:        flip = addr_in[9];
            SWZ_9_10:     flip = addr_in[9] ^ addr_in[10];
            SWZ_9_11:     flip = addr_in[9] ^ addr_in[11];
            SWZ_9_10_11:  flip = addr_in[9] ^ addr_in[10] ^ addr_in[11];
            SWZ_9_17:     flip = addr_in[9] ^ addr_in[17];
            SWZ_9_10_17:  flip = addr_in[9] ^ addr_in[10] ^ addr_in[17];
            default:      flip = 1'b0;
        endcase
    end

    // Rebuild the address with only bit 6 adjusted.
    always_comb begin
        addr_out          = addr_in;
        addr_out[SWZ_BIT] = addr_in[SWZ_BIT] ^ flip;
    end
endmodule

// File: rtl/bit6_swizzle_unit.sv
// Module: bit6_swizzle_unit (top)
// Decodes the memory configuration into X/Y bit-6 swizzle modes on a load
// strobe and applies the mode matching each access's tiling to its address.
// Assumes: ADDR_W >= 18; cfg field positions fixed by parameters.
module bit6_swizzle_unit #(
    parameter int ADDR_W     = 32,
    parameter int CFG_W      = 32,
    parameter int CHMODE_LSB = 0,
    parameter int SEL17_BIT  = 9,
    parameter int XORDIS_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              cfg_l_shaped,
    input  logic [1:0]        acc_tiling,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [2:0]        mode_x,
    output logic [2:0]        mode_y,
    output logic              pin_pages
);
    import swz_pkg::*;

    localparam logic [1:0] TILE_X = 2'b01;
    localparam logic [1:0] TILE_Y = 2'b10;
    localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << 6);

    swz_mode_t dec_x, dec_y, cur_x, cur_y, use_mode;
    logic      dec_unknown;

    swz_mode_decode #(
        .CFG_W(CFG_W), .CHMODE_LSB(CHMODE_LSB),
        .SEL17_BIT(SEL17_BIT), .XORDIS_BIT(XORDIS_BIT)
    ) u_decode (
        .cfg_word(cfg_word), .cfg_l_shaped(cfg_l_shaped),
        .dec_x(dec_x), .dec_y(dec_y), .dec_unknown(dec_unknown)
    );

    swz_mode_regs u_regs (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .dec_x(dec_x), .dec_y(dec_y), .dec_unknown(dec_unknown),
        .mode_x(cur_x), .mode_y(cur_y), .pin_pages(pin_pages)
    );

    // Pick the mode for this access's tiling; untiled uses none.
    always_comb begin
        case (acc_tiling)
            TILE_X:  use_mode = cur_x;
            TILE_Y:  use_mode = cur_y;
            default: use_mode = SWZ_NONE;
        endcase
    end

    swz_addr_xor #(.ADDR_W(ADDR_W)) u_xor (
        .mode(use_mode), .addr_in(acc_addr), .addr_out(out_addr)
    );

    // Export the current mode codes.
    always_comb begin
        mode_x = cur_x;
        mode_y = cur_y;
    end

    // R10: untiled access passes through
    assert_untiled_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_tiling == 2'b00 || acc_tiling == 2'b11) |-> (out_addr == acc_addr));

    // R10: only bit 6 may differ
    assert_only_bit6_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_addr ^ acc_addr) & KEEP_MASK) == '0);

    // R9: a tiled access under mode none is unchanged
    assert_none_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_tiling == TILE_X && mode_x == 3'd0) || (acc_tiling == TILE_Y && mode_y == 3'd0))
        |-> (out_addr == acc_addr));

    // R2: X and Y are either both none or both swizzled
    assert_pair_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_x == 3'd0) == (mode_y == 3'd0));
endmodule

// File: tb/test_bit6_swizzle_unit.sv
module test_bit6_swizzle_unit;
    localparam int AW = 32;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [CW-1:0] cfg_word = '0;
    logic          cfg_l_shaped = 1'b0;
    logic [1:0]    acc_tiling = 2'b00;
    logic [AW-1:0] acc_addr = '0;
    logic [AW-1:0] out_addr;
    logic [2:0]    mode_x, mode_y;
    logic          pin_pages;

    int errors = 0;
    int checks = 0;
    logic [2:0] m_x = 3'd0, m_y = 3'd0;
    logic       m_pin = 1'b0;

    bit6_swizzle_unit i_bit6_swizzle_unit (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .cfg_l_shaped(cfg_l_shaped), .acc_tiling(acc_tiling), .acc_addr(acc_addr),
        .out_addr(out_addr), .mode_x(mode_x), .mode_y(mode_y), .pin_pages(pin_pages)
    );

    always #5 clk = ~clk;

    // Expected {unknown, x, y} from the requirement table.
    function automatic logic [6:0] exp_dec(input logic [CW-1:0] w, input logic l);
        logic [2:0] x, y;
        logic unk;
        unk = 1'b0; x = 3'd0; y = 3'd0;
        if (w == '1 || l || w[1:0] == 2'b11) unk = 1'b1;
        else if (w[1:0] == 2'b10) begin
            if (w[10])      begin x = 3'd2; y = 3'd1; end
            else if (!w[9]) begin x = 3'd4; y = 3'd3; end
            else            begin x = 3'd6; y = 3'd5; end
        end
        return {unk, x, y};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input logic [2:0] m);
        logic f;
        f = 1'b0;
        if (m != 3'd0) f = a[9];
        if (m == 3'd2 || m == 3'd4 || m == 3'd6) f ^= a[10];
        if (m == 3'd3 || m == 3'd4) f ^= a[11];
        if (m == 3'd5 || m == 3'd6) f ^= a[17];
        exp_addr = a;
        exp_addr[6] = a[6] ^ f;
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check({req, " mode_x"}, AW'(mode_x), AW'(m_x));
        check({req, " mode_y"}, AW'(mode_y), AW'(m_y));
        check({req, " pin_pages"}, AW'(pin_pages), AW'(m_pin));
    endtask

    // One cycle: drive on negedge, update model, sample after posedge.
    task automatic step(input logic ld, input logic [CW-1:0] w, input logic l, input string req);
        logic [6:0] d;
        @(negedge clk);
        cfg_load = ld; cfg_word = w; cfg_l_shaped = l;
        @(posedge clk);
        if (!rst_n) begin
            m_x = 0; m_y = 0; m_pin = 0;
        end else if (ld) begin
            d = exp_dec(w, l);
            m_x = d[5:3]; m_y = d[2:0]; m_pin = m_pin | d[6];
        end
        #1;
        check_regs(req);
    endtask

    task automatic probe(input logic [1:0] t, input logic [AW-1:0] a, input string req);
        logic [2:0] m;
        acc_tiling = t; acc_addr = a;
        #1;
        m = (t == 2'b01) ? m_x : (t == 2'b10) ? m_y : 3'd0;
        check(req, out_addr, exp_addr(a, m));
    endtask

    task automatic probe_all(input string req);
        probe(2'b01, 32'h0002_0E40 ^ $urandom, req);
        probe(2'b10, $urandom, req);
        probe(2'b00, $urandom, "R10 untiled 00");
        probe(2'b11, $urandom, "R10 untiled 11");
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        repeat (3) step(1'b1, 32'h0000_0402, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        step(1'b0, '0, 1'b0, "R1 after reset");
        probe_all("R9 reset modes none");

        step(1'b1, 32'h0000_0000, 1'b0, "R2 single channel");
        step(1'b1, 32'h0000_0601, 1'b0, "R2 asymmetric");
        step(1'b1, 32'h0000_0402, 1'b0, "R3 xor disabled");
        probe_all("R9 mode 2/1");
        step(1'b1, 32'h0000_0002, 1'b0, "R4 bit 11");
        probe_all("R9 mode 4/3");
        step(1'b1, 32'h0000_0202, 1'b0, "R5 bit 17");
        probe_all("R9 mode 6/5");
        probe(2'b01, 32'h0002_0000, "R9 bit17 alone flips bit6 X");
        step(1'b0, 32'h0000_0000, 1'b0, "R8 hold without load");
        step(1'b1, 32'h0000_0202, 1'b1, "R6 L-shaped");
        step(1'b1, 32'h0000_0402, 1'b0, "R7 sticky after good load");
        step(1'b1, '1, 1'b0, "R6 all ones");
        step(1'b1, 32'h0000_0003, 1'b0, "R6 reserved code");
        rst_n = 1'b0;
        step(1'b0, '0, 1'b0, "R1 reset clears pin");
        rst_n = 1'b1;
        step(1'b1, 32'h0000_0003, 1'b0, "R6 reserved code sets pin");

        for (int i = 0; i < 400; i++) begin
            logic [CW-1:0] w;
            int sel;
            w = $urandom;
            sel = $urandom_range(0, 19);
            if (sel == 0) w = '1;
            else if (sel < 12) w[1:0] = 2'b10;
            step(($urandom_range(0, 2) == 0), w, ($urandom_range(0, 15) == 0), "R8 random cfg");
            probe_all("R9 random access");
            if (i == 200) begin
                rst_n = 1'b0;
                step(1'b0, '0, 1'b0, "R1 mid-run reset");
                rst_n = 1'b1;
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule